// File: doc/BRIEF.md
# Boot Copy Sequencer

After every hard reset this block keeps the processor stalled while it moves a program image from a read-only boot store into the writable instruction memory. It walks the image one word per clock: it presents a ROM address, latches the word the ROM returns, and writes that word to instruction RAM on the following clock. When the highest image address has been written, the block raises a completion flag and releases the processor. At release the processor's program counter has been held at zero for the whole boot.

The instruction-RAM write port is shared. While the copy runs, the sequencer alone drives it, and any write request from the processor side is dropped. Once the copy is complete, the port passes the processor's requests straight through and stays that way until the next hard reset. A bypass input, sampled on the last reset edge, skips the copy altogether. The processor then starts from whatever the RAM already holds.

Top module: `boot_copy_seq`

## Requirements
- R1: On any clock edge with `rst_n` low, the outputs settle to `cpu_run`=0, `pc_zero`=1, `boot_done`=0 and `iram_we`=0.
- R2: Without bypass, the sequencer writes RAM addresses 0, 1, ..., IMG_WORDS-1 on consecutive clocks, each exactly once. The first write is visible after the first edge with `rst_n` high. Each write carries the ROM word of the same address, and `rom_addr` shows that address one clock before the write.
- R3: After completion, every instruction-RAM word 0..IMG_WORDS-1 equals the boot ROM word at the same address.
- R4: Without bypass, `boot_done` rises after exactly IMG_WORDS+1 rising edges with `rst_n` high. Once high, it stays high until the next reset.
- R5: Whenever `boot_done` is low, `cpu_run` is 0 and `pc_zero` is 1. Whenever `boot_done` is high, `cpu_run` is 1 and `pc_zero` is 0.
- R6: Before completion, processor-side write requests have no effect on the RAM port. `iram_we` and `iram_addr` follow only the sequencer.
- R7: After completion, `iram_we`, `iram_addr` and `iram_wdata` equal the processor-side `cpu_iram_*` inputs on every cycle, and the sequencer issues no write.
- R8: If `skip_req` is 1 on the last reset edge, `boot_done` rises after the first edge with `rst_n` high, no write is issued during boot, and the RAM keeps its previous contents.
- R9: Changes of `skip_req` while `rst_n` is high have no effect on the copy sequence or on its timing.
- R10: Every hard reset restarts the copy from address 0, including a reset applied part-way through a copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low hard reset |
| skip_req | input | 1 | Copy bypass request, sampled while reset is active |
| rom_addr | output | AW | Boot ROM read address |
| rom_data | input | DW | Boot ROM read word for `rom_addr` (combinational read) |
| cpu_iram_we | input | 1 | Processor-side RAM write enable |
| cpu_iram_addr | input | AW | Processor-side RAM write address |
| cpu_iram_wdata | input | DW | Processor-side RAM write data |
| iram_we | output | 1 | Instruction RAM write enable |
| iram_addr | output | AW | Instruction RAM write address |
| iram_wdata | output | DW | Instruction RAM write data |
| cpu_run | output | 1 | Processor may execute (1) or is held (0) |
| pc_zero | output | 1 | Forces the processor program counter to zero |
| boot_done | output | 1 | Copy finished or bypassed; sticky until reset |

## Verification
The bench checks the first and last image words and the exact release cycle. An off-by-one in the last-address compare shows up either as a missing final word or as a release one clock early or late. It drives processor-side writes at random throughout the boot, so a port multiplexer that switched over early, or leaked those writes, would corrupt the copied image or the address sequence. It resets once part-way through a copy and changes the bypass input after reset is released. A design that kept its counter across reset, or sampled the bypass at the wrong time, would then start at a nonzero address or skip a copy that should run. A bypassed boot must leave a known RAM image intact and release after a single clock.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;

  // Sequencer phases; the order matters only for readability.
  typedef enum logic [1:0] {
    BC_COPY  = 2'd0,  // issuing ROM reads and RAM writes
    BC_DRAIN = 2'd1,  // last ROM word latched, final write pending
    BC_DONE  = 2'd2   // RAM port handed to the processor
  } bc_state_e;

  // Number of clock edges from reset release to completion flag.
  function automatic int unsigned boot_cycles(input int unsigned words);
    return words + 1;
  endfunction

endpackage

// File: rtl/boot_copy_fetch.sv
module boot_copy_fetch #(
  parameter int AW        = 8,
  parameter int IMG_WORDS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_last
);

  localparam logic [AW-1:0] LAST_A = AW'(IMG_WORDS - 1);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (advance && (addr_q != LAST_A)) begin
      addr_q <= step_addr(addr_q);
    end
  end

  assign fetch_addr = addr_q;
  assign fetch_last = (addr_q == LAST_A);

endmodule

// File: rtl/boot_copy_wstage.sv
module boot_copy_wstage #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int IMG_WORDS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] cap_addr,
  input  logic [DW-1:0] cap_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_last
);

  localparam logic [AW-1:0] LAST_A = AW'(IMG_WORDS - 1);

  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= capture;
      if (capture) begin
        addr_q <= cap_addr;
        data_q <= cap_data;
      end
    end
  end

  assign wr_valid = valid_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign wr_last  = valid_q && (addr_q == LAST_A);

endmodule

// File: rtl/boot_copy_fsm.sv
module boot_copy_fsm
  import boot_copy_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic skip_req,
  input  logic fetch_last,
  input  logic wr_last,
  output logic fetch_en,
  output logic done
);

  bc_state_e state_q, state_d;
  logic      done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BC_COPY:  if (fetch_last) state_d = BC_DRAIN;
      BC_DRAIN: if (wr_last)    state_d = BC_DONE;
      BC_DONE:  state_d = BC_DONE;
      default:  state_d = BC_DONE;
    endcase
  end

  // Bypass request is only looked at on reset edges.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= skip_req ? BC_DONE : BC_COPY;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_d == BC_DONE);
    end
  end

  assign fetch_en = (state_q == BC_COPY);
  assign done     = done_q;

endmodule

// File: rtl/boot_copy_portmux.sv
module boot_copy_portmux #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          sel_cpu,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  output logic          out_we,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);

  always_comb begin
    if (sel_cpu) begin
      out_we   = cpu_we;
      out_addr = cpu_addr;
      out_data = cpu_data;
    end else begin
      out_we   = ld_we;
      out_addr = ld_addr;
      out_data = ld_data;
    end
  end

endmodule

// File: rtl/boot_copy_seq.sv
module boot_copy_seq #(
  parameter int AW        = 8,
  parameter int DW        = 8,
  parameter int IMG_WORDS = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          skip_req,
  output logic [AW-1:0] rom_addr,
  input  logic [DW-1:0] rom_data,
  input  logic          cpu_iram_we,
  input  logic [AW-1:0] cpu_iram_addr,
  input  logic [DW-1:0] cpu_iram_wdata,
  output logic          iram_we,
  output logic [AW-1:0] iram_addr,
  output logic [DW-1:0] iram_wdata,
  output logic          cpu_run,
  output logic          pc_zero,
  output logic          boot_done
);

  // Named internal events, also observed by the bound checker.
  logic          fetch_en;
  logic          fetch_last;
  logic [AW-1:0] fetch_addr;
  logic          ld_we;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;
  logic          ld_last;
  logic          done;

  boot_copy_fetch #(.AW(AW), .IMG_WORDS(IMG_WORDS)) fetch_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (fetch_en),
    .fetch_addr (fetch_addr),
    .fetch_last (fetch_last)
  );

  boot_copy_wstage #(.AW(AW), .DW(DW), .IMG_WORDS(IMG_WORDS)) wstage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (fetch_en),
    .cap_addr (fetch_addr),
    .cap_data (rom_data),
    .wr_valid (ld_we),
    .wr_addr  (ld_addr),
    .wr_data  (ld_data),
    .wr_last  (ld_last)
  );

  boot_copy_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .skip_req   (skip_req),
    .fetch_last (fetch_last),
    .wr_last    (ld_last),
    .fetch_en   (fetch_en),
    .done       (done)
  );

  boot_copy_portmux #(.AW(AW), .DW(DW)) mux_i (
    .sel_cpu  (done),
    .ld_we    (ld_we),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .cpu_we   (cpu_iram_we),
    .cpu_addr (cpu_iram_addr),
    .cpu_data (cpu_iram_wdata),
    .out_we   (iram_we),
    .out_addr (iram_addr),
    .out_data (iram_wdata)
  );

  assign rom_addr  = fetch_addr;
  assign boot_done = done;
  assign cpu_run   = done;
  assign pc_zero   = ~done;

endmodule

// File: rtl/boot_copy_seq_chk.sv
module boot_copy_seq_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          boot_done,
  input logic          cpu_run,
  input logic          pc_zero,
  input logic          iram_we,
  input logic          cpu_iram_we,
  input logic          ld_we,
  input logic [AW-1:0] ld_addr
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!cpu_run && !iram_we && !boot_done));

  // R5
  hold_while_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_done |-> (!cpu_run && pc_zero));

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && $past(ld_we)) |-> (ld_addr == $past(ld_addr) + AW'(1)));

  // R10
  first_write_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_we) |-> (ld_addr == '0));

  // R7
  loader_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> !ld_we);

  // R6
  cpu_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_done && cpu_iram_we && !ld_we) |-> !iram_we);

endmodule

bind boot_copy_seq boot_copy_seq_chk #(.AW(AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .boot_done   (boot_done),
  .cpu_run     (cpu_run),
  .pc_zero     (pc_zero),
  .iram_we     (iram_we),
  .cpu_iram_we (cpu_iram_we),
  .ld_we       (ld_we),
  .ld_addr     (ld_addr)
);

// File: tb/boot_copy_seq_tb_top.sv
module boot_copy_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 8;
  localparam int DW         = 8;
  localparam int WORDS      = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          skip_req = 1'b0;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_data;
  logic          cpu_iram_we = 1'b0;
  logic [AW-1:0] cpu_iram_addr = '0;
  logic [DW-1:0] cpu_iram_wdata = '0;
  logic          iram_we;
  logic [AW-1:0] iram_addr;
  logic [DW-1:0] iram_wdata;
  logic          cpu_run, pc_zero, boot_done;

  logic [DW-1:0] rom [WORDS];
  logic [DW-1:0] ram [WORDS];
  logic [DW-1:0] snap [WORDS];

  int vectors = 0;
  int errors  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_copy_seq #(.AW(AW), .DW(DW), .IMG_WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .skip_req(skip_req),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .cpu_iram_we(cpu_iram_we), .cpu_iram_addr(cpu_iram_addr),
    .cpu_iram_wdata(cpu_iram_wdata),
    .iram_we(iram_we), .iram_addr(iram_addr), .iram_wdata(iram_wdata),
    .cpu_run(cpu_run), .pc_zero(pc_zero), .boot_done(boot_done)
  );

  assign rom_data = rom[rom_addr];

  always @(posedge clk) if (iram_we) ram[iram_addr] <= iram_wdata;

  function automatic logic [DW-1:0] image_word(input int img, input int a);
    return DW'((a * (2 * img + 7)) ^ (img * 8'h3B) ^ $urandom_range(255, 0));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic load_rom(input int img);
    for (int a = 0; a < WORDS; a++) rom[a] = image_word(img, a);
  endtask

  task automatic drive_cpu_random();
    cpu_iram_we    = 1'($urandom_range(1, 0));
    cpu_iram_addr  = AW'($urandom);
    cpu_iram_wdata = DW'($urandom);
  endtask

  task automatic apply_reset(input bit skip, input int n);
    @(negedge clk);
    rst_n    = 1'b0;
    skip_req = skip;
    drive_cpu_random();
    repeat (n) @(posedge clk);
    @(negedge clk);
    check(!cpu_run && pc_zero && !boot_done && !iram_we, "R1", "reset outputs",
          {cpu_run, pc_zero, boot_done, iram_we}, 4'b0100);
    rst_n    = 1'b1;
    // R9: bypass value after release must not matter
    skip_req = 1'($urandom_range(1, 0));
    drive_cpu_random();
  endtask

  // Edge k is the k-th rising edge with rst_n high; sampled at the next negedge.
  task automatic run_boot(input bit skipped);
    int last_k;
    last_k = skipped ? 1 : WORDS + 1;
    for (int k = 1; k <= last_k; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (k < last_k) begin
        check(iram_we && iram_addr == AW'(k-1), "R2", "write address",
              {iram_we, iram_addr}, {1'b1, AW'(k-1)});
        check(iram_wdata == rom[k-1], "R2", "write data", iram_wdata, rom[k-1]);
        if (k < WORDS)
          check(rom_addr == AW'(k), "R2", "rom address lead", rom_addr, k);
        check(!boot_done && !cpu_run && pc_zero, "R5", "cpu held",
              {boot_done, cpu_run, pc_zero}, 3'b001);
        if (cpu_iram_we)
          check(iram_addr == AW'(k-1), "R6", "cpu write ignored", iram_addr, k-1);
        if (k == 1)
          check(iram_addr == '0, "R10", "copy starts at zero", iram_addr, 0);
      end else begin
        check(boot_done && cpu_run && !pc_zero,
              skipped ? "R8" : "R4", "release cycle",
              {boot_done, cpu_run, pc_zero}, 3'b110);
        for (int a = 0; a < WORDS; a++) begin
          if (skipped)
            check(ram[a] == snap[a], "R8", "ram retained", ram[a], snap[a]);
          else if (a == 0 || a == WORDS-1 || a % 17 == 0)
            check(ram[a] == rom[a], "R3", "ram image", ram[a], rom[a]);
        end
      end
      drive_cpu_random();
      skip_req = 1'($urandom_range(1, 0));
    end
  endtask

  task automatic run_cpu_phase(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(iram_we == cpu_iram_we && iram_addr == cpu_iram_addr &&
            iram_wdata == cpu_iram_wdata, "R7", "cpu passthrough",
            {iram_we, iram_addr, iram_wdata},
            {cpu_iram_we, cpu_iram_addr, cpu_iram_wdata});
      check(boot_done && cpu_run, "R4", "done sticky", {boot_done, cpu_run}, 2'b11);
      drive_cpu_random();
      skip_req = 1'($urandom_range(1, 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not end actual=0 expected=1");
    summary();
  end

  initial begin
    void'($urandom(32'h0B00_7C0D));
    for (int a = 0; a < WORDS; a++) ram[a] = '0;
    load_rom(1);
    apply_reset(1'b0, 3);
    run_boot(1'b0);
    run_cpu_phase(40);

    // R10: reset part-way through a copy, then a fresh image
    load_rom(2);
    apply_reset(1'b0, 2);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      drive_cpu_random();
      skip_req = 1'($urandom_range(1, 0));
    end
    load_rom(3);
    apply_reset(1'b0, 4);
    run_boot(1'b0);
    run_cpu_phase(40);

    // R8: bypass keeps the current RAM contents
    load_rom(4);
    apply_reset(1'b1, 2);
    for (int a = 0; a < WORDS; a++) snap[a] = ram[a];
    run_boot(1'b1);
    run_cpu_phase(30);

    // R10: a later plain reset copies again
    apply_reset(1'b0, 1);
    run_boot(1'b0);
    run_cpu_phase(20);
    summary();
  end

endmodule